// File: doc/BRIEF.md
# UART FIFO Control and Interrupt Logic

This block sits between the serial shifters of a UART and the host side. It holds a receive FIFO and a transmit FIFO, each 64 entries deep by default. It decodes a one-byte FIFO control word and produces the line-status flags and interrupt requests that depend on FIFO occupancy. Each receive entry carries its data byte together with three error marks: parity, framing and break. The FIFO-error summary flag and the sticky status bits are built from those marks.

The control word turns FIFO mode on or off and flushes either FIFO. It also selects the receive trigger level. When FIFO mode is off, each direction shrinks to a single holding register and the trigger level is ignored.

All four data paths are valid/ready streams, and a transfer happens on a clock edge where valid and ready are both high.
- The host-side ports (receive pop, transmit push) and the transmit shifter port follow normal back-pressure rules: a producer holds its valid and data until ready is seen.
- The receive shifter cannot stall. Asserting `rx_in_valid` while `rx_in_ready` is low therefore drops the byte and records an overrun.
- The ready outputs depend only on stored state, never combinationally on the opposite valid.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, FIFO mode is off, the trigger code is 00, both FIFOs are empty, and `tx_req` is 1. `data_ready`, `fifo_err`, all sticky status bits and all interrupt outputs are 0.
- R2: A write on the configuration port loads the control byte, which uses these bit positions:
  - bit 0 is the FIFO enable;
  - bit 1 flushes the receive FIFO;
  - bit 2 flushes the transmit FIFO;
  - bits 7:6 are the trigger code;
  - bits 5:3 are ignored.
  The flush bits act only on the cycle of the write and are not kept. A write with bits 2:1 at 0 and bit 0 at 1 leaves both FIFOs' contents untouched.
- R3: In FIFO mode each FIFO accepts up to DEPTH entries and delivers them in order. The receive output presents the oldest entry's byte and its three error marks. Each ready output is low exactly when its FIFO is full.
- R4: `rx_in_valid` high while `rx_in_ready` is low drops the byte and sets `overrun_st` on the next edge.
- R5: In FIFO mode, `rx_irq` is high when `rx_int_en` is 1 and the receive count is at least the threshold selected by the trigger code: 00 selects 1, 01 selects 8, 10 selects 16 and 11 selects 32.
- R6: With FIFO mode off, each FIFO holds at most one entry. `rx_irq` is then `rx_int_en` AND (holding register full), whatever the trigger code.
- R7: A receive flush empties the receive FIFO on the write edge. After that edge, `data_ready`, `fifo_err` and `rx_irq` are all 0.
  - A receive push in the same cycle is discarded without setting overrun.
  - The sticky status bits are left unchanged.
  - The transmit FIFO is not affected.
- R8: A transmit flush empties the transmit FIFO on the write edge, so `tx_req` is 1 afterwards. A byte already handed out on the transmit output is not recalled, and the receive FIFO is not affected.
- R9: A configuration write with bit 0 at 0 empties both FIFOs and enters single-entry mode. A write with bit 0 at 1 enables both FIFOs.
- R10: `fifo_err` is 1 exactly when at least one stored receive entry has a parity, framing or break mark set.
- R11: `parity_st`, `framing_st` and `break_st` are set by an accepted receive entry carrying the matching mark. Together with `overrun_st`, they stay set until a cycle with `status_clr` high. A new event in that same cycle wins over the clear.
- R12: `tx_irq` equals `tx_int_en` AND `tx_req`, and `irq_pending` is `rx_irq` OR `tx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| rx_int_en | input | 1 | Receive-data interrupt enable |
| tx_int_en | input | 1 | Transmit-request interrupt enable |
| status_clr | input | 1 | Clears the sticky status bits |
| rx_in_valid | input | 1 | Receive shifter has a byte |
| rx_in_ready | output | 1 | Receive FIFO has room |
| rx_in_data | input | 8 | Received byte |
| rx_in_perr | input | 1 | Parity error mark of the received byte |
| rx_in_ferr | input | 1 | Framing error mark of the received byte |
| rx_in_brk | input | 1 | Break mark of the received byte |
| rx_out_valid | output | 1 | Receive FIFO not empty |
| rx_out_ready | input | 1 | Host takes the oldest entry |
| rx_out_data | output | 8 | Oldest received byte |
| rx_out_perr | output | 1 | Parity mark of the oldest entry |
| rx_out_ferr | output | 1 | Framing mark of the oldest entry |
| rx_out_brk | output | 1 | Break mark of the oldest entry |
| tx_in_valid | input | 1 | Host offers a byte to send |
| tx_in_ready | output | 1 | Transmit FIFO has room |
| tx_in_data | input | 8 | Byte to send |
| tx_out_valid | output | 1 | Transmit FIFO not empty |
| tx_out_ready | input | 1 | Transmit shifter takes a byte |
| tx_out_data | output | 8 | Oldest byte to send |
| data_ready | output | 1 | Receive data present |
| tx_req | output | 1 | Transmit FIFO empty, more data wanted |
| fifo_err | output | 1 | Some stored receive entry carries an error mark |
| overrun_st | output | 1 | Sticky receive overrun |
| parity_st | output | 1 | Sticky parity error |
| framing_st | output | 1 | Sticky framing error |
| break_st | output | 1 | Sticky break |
| rx_irq | output | 1 | Receive-data-available interrupt |
| tx_irq | output | 1 | Transmit-request interrupt |
| irq_pending | output | 1 | Any interrupt pending |

## Verification
The hardest state to reach from the ports has three ingredients at once:
- a completely full 64-entry receive FIFO holding several error-marked entries;
- sticky status bits set;
- a receive flush or a FIFO-disable write landing at that moment.

Random traffic rarely fills the FIFO, because pops keep draining it. The bench therefore runs a directed fill with pops held off and error marks injected, then forces overruns and issues the flush. It follows this with random phases whose push and pop rates are skewed so that occupancy repeatedly sweeps from empty to full across every trigger code and both modes.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Control byte field positions (decoded by the configuration register).
  localparam int unsigned CFG_EN_BIT    = 0;
  localparam int unsigned CFG_RXFL_BIT  = 1;
  localparam int unsigned CFG_TXFL_BIT  = 2;
  localparam int unsigned CFG_TRIG_LSB  = 6;
  localparam int unsigned CFG_W         = 8;

  // Number of error marks stored with each receive byte.
  localparam int unsigned ERR_W = 3;

  typedef enum logic [1:0] {
    TRIG_LVL_A = 2'b00,
    TRIG_LVL_B = 2'b01,
    TRIG_LVL_C = 2'b10,
    TRIG_LVL_D = 2'b11
  } trig_code_e;

  // Threshold in entries: 1, 8, 16 or 32.
  function automatic int unsigned trig_level(trig_code_e code);
    int unsigned lvl;
    if (code == TRIG_LVL_A) lvl = 1;
    else                    lvl = 32'd4 << code;
    return lvl;
  endfunction

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
  import uart_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic             fifo_on,
  output trig_code_e       trig,
  output logic             rx_flush,
  output logic             tx_flush
);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^wdata[CFG_TRIG_LSB-1:CFG_TXFL_BIT+1];

  // Stored fields: enable and trigger code only; flush bits are one-shot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_on <= 1'b0;
      trig    <= TRIG_LVL_A;
    end else if (we) begin
      fifo_on <= wdata[CFG_EN_BIT];
      trig    <= trig_code_e'(wdata[CFG_TRIG_LSB +: 2]);
    end
  end

  // Flush strobes act at the write edge; disabling FIFOs flushes both.
  always_comb begin
    rx_flush = we && (wdata[CFG_RXFL_BIT] || !wdata[CFG_EN_BIT]);
    tx_flush = we && (wdata[CFG_TXFL_BIT] || !wdata[CFG_EN_BIT]);
  end

  // R2: without a write the stored fields do not move.
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(fifo_on) && $stable(trig));

endmodule

// File: rtl/uart_fifo_store.sv
module uart_fifo_store #(
  parameter int unsigned W     = 11,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             single,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             do_push;
  logic             do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && !flush;
  assign do_pop  = pop  && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    dout  = mem[rd_ptr];
    empty = (count == '0);
    full  = single ? !empty : (count == CNT_W'(DEPTH));
  end

  // R3: a push is only offered when there is room.
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  // R3: a pop is only offered when data is present.
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
  // R7 / R8: a flush leaves the store empty.
  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  // R6: single-entry mode never holds more than one entry.
  assert_single_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    single |-> (count <= CNT_W'(1)));

endmodule

// File: rtl/uart_rx_trigger.sv
module uart_rx_trigger
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_on,
  input  trig_code_e       code,
  input  logic [CNT_W-1:0] count,
  output logic             hit
);

  logic [CNT_W-1:0] thr;

  always_comb begin
    int unsigned lvl;
    lvl = trig_level(code);
    if (lvl > DEPTH) lvl = DEPTH;
    thr = CNT_W'(lvl);
    hit = fifo_on ? (count >= thr) : (count != '0);
  end

  // R6: in single-entry mode a hit means the holding register is full.
  assert_single_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && hit) |-> (count == CNT_W'(1)));
  // R5: no hit on an empty FIFO.
  assert_no_empty_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !hit);

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              rx_int_en,
  input  logic              tx_int_en,
  input  logic              status_clr,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [DATA_W-1:0] rx_in_data,
  input  logic              rx_in_perr,
  input  logic              rx_in_ferr,
  input  logic              rx_in_brk,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [DATA_W-1:0] rx_out_data,
  output logic              rx_out_perr,
  output logic              rx_out_ferr,
  output logic              rx_out_brk,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  output logic              data_ready,
  output logic              tx_req,
  output logic              fifo_err,
  output logic              overrun_st,
  output logic              parity_st,
  output logic              framing_st,
  output logic              break_st,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              irq_pending
);

  localparam int unsigned RX_W  = DATA_W + ERR_W;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             fifo_on;
  trig_code_e       trig;
  logic             rx_flush;
  logic             tx_flush;

  logic             rx_push, rx_pop, rx_full, rx_empty;
  logic [RX_W-1:0]  rx_din, rx_dout;
  logic [CNT_W-1:0] rx_count;
  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic [CNT_W-1:0] tx_count_unused;
  logic             rx_hit;

  logic [CNT_W-1:0] err_cnt;
  logic             in_err, out_err;

  uart_fifo_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .fifo_on  (fifo_on),
    .trig     (trig),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  // Receive entry layout: {brk, ferr, perr, data}.
  assign rx_din  = {rx_in_brk, rx_in_ferr, rx_in_perr, rx_in_data};
  assign rx_push = rx_in_valid && rx_in_ready;
  assign rx_pop  = rx_out_ready && rx_out_valid;

  uart_fifo_store #(.W(RX_W), .DEPTH(DEPTH)) u_rx_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (rx_flush),
    .single (!fifo_on),
    .push   (rx_push),
    .din    (rx_din),
    .pop    (rx_pop),
    .dout   (rx_dout),
    .count  (rx_count),
    .full   (rx_full),
    .empty  (rx_empty)
  );

  assign tx_push = tx_in_valid && tx_in_ready;
  assign tx_pop  = tx_out_ready && tx_out_valid;

  uart_fifo_store #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (tx_flush),
    .single (!fifo_on),
    .push   (tx_push),
    .din    (tx_in_data),
    .pop    (tx_pop),
    .dout   (tx_out_data),
    .count  (tx_count_unused),
    .full   (tx_full),
    .empty  (tx_empty)
  );

  uart_rx_trigger #(.DEPTH(DEPTH)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_on (fifo_on),
    .code    (trig),
    .count   (rx_count),
    .hit     (rx_hit)
  );

  // Stream side.
  always_comb begin
    rx_in_ready  = !rx_full;
    rx_out_valid = !rx_empty;
    rx_out_data  = rx_dout[DATA_W-1:0];
    rx_out_perr  = rx_dout[DATA_W];
    rx_out_ferr  = rx_dout[DATA_W+1];
    rx_out_brk   = rx_dout[DATA_W+2];
    tx_in_ready  = !tx_full;
    tx_out_valid = !tx_empty;
  end

  // Count of stored receive entries that carry any error mark.
  assign in_err  = rx_in_perr || rx_in_ferr || rx_in_brk;
  assign out_err = |rx_dout[RX_W-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
    end else if (rx_flush) begin
      err_cnt <= '0;
    end else begin
      case ({rx_push && in_err, rx_pop && out_err})
        2'b10:   err_cnt <= err_cnt + 1'b1;
        2'b01:   err_cnt <= err_cnt - 1'b1;
        default: err_cnt <= err_cnt;
      endcase
    end
  end

  // Sticky line status: set by events, cleared by status_clr, immune to flush.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun_st <= 1'b0;
      parity_st  <= 1'b0;
      framing_st <= 1'b0;
      break_st   <= 1'b0;
    end else begin
      overrun_st <= (overrun_st && !status_clr) || (rx_in_valid && !rx_in_ready);
      parity_st  <= (parity_st  && !status_clr) || (rx_push && rx_in_perr);
      framing_st <= (framing_st && !status_clr) || (rx_push && rx_in_ferr);
      break_st   <= (break_st   && !status_clr) || (rx_push && rx_in_brk);
    end
  end

  always_comb begin
    data_ready  = !rx_empty;
    tx_req      = tx_empty;
    fifo_err    = (err_cnt != '0);
    rx_irq      = rx_int_en && rx_hit;
    tx_irq      = tx_int_en && tx_req;
    irq_pending = rx_irq || tx_irq;
  end

  // R4: a dropped receive byte records an overrun.
  assert_overrun_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && !rx_in_ready) |=> overrun_st);
  // R7: after a receive flush nothing receive-related is pending.
  assert_rx_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (!data_ready && !fifo_err && !rx_irq));
  // R7: a receive flush keeps sticky status.
  assert_flush_keeps_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush && !status_clr && overrun_st) |=> overrun_st);
  // R8: after a transmit flush the block requests data.
  assert_tx_flush_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_req);
  // R10: error entries can only exist while data is stored.
  assert_err_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err |-> data_ready);
  // R11: sticky bits fall only on a clear request.
  assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(parity_st) |-> $past(status_clr));

endmodule

// File: tb/tb_uart_fifo_ctrl.sv
module tb_uart_fifo_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 0;
  logic [7:0] cfg_wdata = 0;
  logic       rx_int_en = 0, tx_int_en = 0, status_clr = 0;
  logic       rx_in_valid = 0, rx_in_perr = 0, rx_in_ferr = 0, rx_in_brk = 0;
  logic [7:0] rx_in_data = 0;
  logic       rx_out_ready = 0;
  logic       tx_in_valid = 0, tx_out_ready = 0;
  logic [7:0] tx_in_data = 0;

  logic       rx_in_ready, rx_out_valid, rx_out_perr, rx_out_ferr, rx_out_brk;
  logic [7:0] rx_out_data, tx_out_data;
  logic       tx_in_ready, tx_out_valid;
  logic       data_ready, tx_req, fifo_err, overrun_st, parity_st, framing_st, break_st;
  logic       rx_irq, tx_irq, irq_pending;

  uart_fifo_ctrl #(.DATA_W(8), .DEPTH(DEPTH)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // Reference model state.
  int unsigned rxq[$];
  logic [7:0]  txq[$];
  bit       m_fen;
  bit [1:0] m_trig;
  bit       m_ovr, m_par, m_frm, m_brk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL R1 watchdog: got %0d cycles, expected <= %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  function automatic int thr_of(bit [1:0] c);
    return (c == 2'b00) ? 1 : (4 << c);
  endfunction

  function automatic bit exp_fifo_err();
    foreach (rxq[i]) if (rxq[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  // Advance the model by one edge using the inputs currently driven.
  task automatic model_step();
    int  cap;
    bit  rrdy, trdy, fr, ft, racc, rpop, tacc, tpop;
    cap  = m_fen ? DEPTH : 1;
    rrdy = rxq.size() < cap;
    trdy = txq.size() < cap;
    fr   = cfg_we && (cfg_wdata[1] || !cfg_wdata[0]);
    ft   = cfg_we && (cfg_wdata[2] || !cfg_wdata[0]);
    racc = rx_in_valid && rrdy;
    rpop = rx_out_ready && rxq.size() > 0;
    tacc = tx_in_valid && trdy;
    tpop = tx_out_ready && txq.size() > 0;
    m_ovr = (m_ovr && !status_clr) || (rx_in_valid && !rrdy);
    m_par = (m_par && !status_clr) || (racc && rx_in_perr);
    m_frm = (m_frm && !status_clr) || (racc && rx_in_ferr);
    m_brk = (m_brk && !status_clr) || (racc && rx_in_brk);
    if (fr) rxq.delete();
    else begin
      if (rpop) void'(rxq.pop_front());
      if (racc) rxq.push_back({21'd0, rx_in_brk, rx_in_ferr, rx_in_perr, rx_in_data});
    end
    if (ft) txq.delete();
    else begin
      if (tpop) void'(txq.pop_front());
      if (tacc) txq.push_back(tx_in_data);
    end
    if (cfg_we) begin
      m_fen  = cfg_wdata[0];
      m_trig = cfg_wdata[7:6];
    end
  endtask

  task automatic compare(string ctx);
    int  cap;
    bit  exp_rirq;
    cap = m_fen ? DEPTH : 1;
    exp_rirq = rx_int_en && (m_fen ? (rxq.size() >= thr_of(m_trig)) : (rxq.size() > 0));
    chk({m_fen ? "R3" : "R6", " rx_in_ready ", ctx}, rx_in_ready, rxq.size() < cap);
    chk({m_fen ? "R3" : "R6", " tx_in_ready ", ctx}, tx_in_ready, txq.size() < cap);
    chk({"R3 rx_out_valid ", ctx}, rx_out_valid, rxq.size() > 0);
    chk({"R3 tx_out_valid ", ctx}, tx_out_valid, txq.size() > 0);
    if (rxq.size() > 0) begin
      chk({"R3 rx_out entry ", ctx},
          {rx_out_brk, rx_out_ferr, rx_out_perr, rx_out_data}, rxq[0][10:0]);
    end
    if (txq.size() > 0) chk({"R3 tx_out_data ", ctx}, tx_out_data, txq[0]);
    chk({"R7 data_ready ", ctx}, data_ready, rxq.size() > 0);
    chk({"R8 tx_req ", ctx}, tx_req, txq.size() == 0);
    chk({"R10 fifo_err ", ctx}, fifo_err, exp_fifo_err());
    chk({"R4 overrun_st ", ctx}, overrun_st, m_ovr);
    chk({"R11 sticky ", ctx}, {parity_st, framing_st, break_st}, {m_par, m_frm, m_brk});
    chk({m_fen ? "R5" : "R6", " rx_irq ", ctx}, rx_irq, exp_rirq);
    chk({"R12 tx_irq ", ctx}, tx_irq, tx_int_en && (txq.size() == 0));
    chk({"R12 irq_pending ", ctx}, irq_pending, exp_rirq || (tx_int_en && (txq.size() == 0)));
  endtask

  task automatic idle();
    cfg_we = 0; status_clr = 0;
    rx_in_valid = 0; rx_in_perr = 0; rx_in_ferr = 0; rx_in_brk = 0;
    rx_out_ready = 0; tx_in_valid = 0; tx_out_ready = 0;
  endtask

  task automatic tick(string ctx);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(ctx);
  endtask

  task automatic cfg_write(logic [7:0] v, string ctx);
    idle(); cfg_we = 1; cfg_wdata = v;
    tick(ctx);
    idle();
  endtask

  initial begin
    void'($urandom(32'h5EED_0A17));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state.
    chk("R1 tx_req after reset", tx_req, 1);
    chk("R1 data_ready after reset", data_ready, 0);
    chk("R1 fifo_err after reset", fifo_err, 0);
    chk("R1 sticky after reset", {overrun_st, parity_st, framing_st, break_st}, 4'h0);
    chk("R1 irq after reset", {rx_irq, tx_irq, irq_pending}, 3'b000);
    chk("R1 single-entry mode after reset", rx_in_ready, 1);

    // R6: single-entry mode, trigger code ignored.
    rx_int_en = 1;
    cfg_write(8'hC0, "R9 disable write with trig 11");
    rx_in_valid = 1; rx_in_data = 8'h5A; tick("R6 first byte");
    chk("R6 rx_irq with one entry, trig 11", rx_irq, 1);
    rx_in_data = 8'h5B; tick("R6 second byte dropped");
    chk("R4 overrun in single mode", overrun_st, 1);
    idle(); status_clr = 1; tick("R11 clear"); idle();

    // R3/R5: fill the FIFO with error marks, sweep thresholds.
    cfg_write(8'b1100_0001, "R9 enable trig 11");
    for (int i = 0; i < DEPTH; i++) begin
      rx_in_valid = 1; rx_in_data = 8'(i);
      rx_in_perr = (i % 7 == 3); rx_in_ferr = (i % 11 == 5); rx_in_brk = (i == 40);
      tick("R3 fill");
    end
    chk("R3 full rx_in_ready", rx_in_ready, 0);
    chk("R5 trig 11 at 64", rx_irq, 1);
    rx_in_perr = 0; rx_in_ferr = 0; rx_in_brk = 0;
    rx_in_valid = 1; rx_in_data = 8'hEE; tick("R4 overrun on full");
    chk("R4 overrun on full FIFO", overrun_st, 1);
    idle();
    // R2: write trigger only, contents kept.
    cfg_write(8'b0100_0001, "R2 trigger write keeps data");
    chk("R2 contents kept after control write", rx_out_valid, 1);
    // Transmit side content for R7 isolation.
    tx_in_valid = 1; tx_in_data = 8'h33; tick("R3 tx push"); idle();
    // R7: flush the receive FIFO, with a push in the same cycle.
    cfg_we = 1; cfg_wdata = 8'b0100_0011; rx_in_valid = 1; rx_in_data = 8'h77;
    tick("R7 rx flush");
    idle();
    chk("R7 data_ready after flush", data_ready, 0);
    chk("R7 sticky overrun kept", overrun_st, 1);
    chk("R7 tx FIFO untouched", tx_out_valid, 1);
    // R8: transmit flush raises tx_irq.
    tx_int_en = 1;
    cfg_write(8'b0100_0101, "R8 tx flush");
    chk("R8 tx_irq after flush", tx_irq, 1);
    // R9: disable empties both.
    rx_in_valid = 1; tx_in_valid = 1; tick("R9 load"); idle();
    cfg_write(8'b0000_0000, "R9 disable flushes");
    chk("R9 rx empty after disable", rx_out_valid, 0);
    chk("R9 tx empty after disable", tx_out_valid, 0);

    // Random phases with skewed rates.
    for (int ph = 0; ph < 60; ph++) begin
      int push_p, pop_p;
      push_p = 20 + $urandom_range(0, 75);
      pop_p  = 5 + $urandom_range(0, 80);
      for (int c = 0; c < 120; c++) begin
        cfg_we = ($urandom_range(0, 79) == 0);
        cfg_wdata = {2'($urandom), 3'($urandom),
                     ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
                     ($urandom_range(0, 9) != 0)};
        status_clr   = ($urandom_range(0, 59) == 0);
        rx_int_en    = ($urandom_range(0, 3) != 0);
        tx_int_en    = ($urandom_range(0, 1) != 0);
        rx_in_valid  = ($urandom_range(0, 99) < push_p);
        rx_in_data   = 8'($urandom);
        rx_in_perr   = ($urandom_range(0, 9) == 0);
        rx_in_ferr   = ($urandom_range(0, 12) == 0);
        rx_in_brk    = ($urandom_range(0, 20) == 0);
        rx_out_ready = ($urandom_range(0, 99) < pop_p);
        tx_in_valid  = ($urandom_range(0, 99) < push_p);
        tx_in_data   = 8'($urandom);
        tx_out_ready = ($urandom_range(0, 99) < pop_p);
        tick("random");
      end
    end
    idle();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule